// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block keeps two alarm settings, each made of a seconds, minutes, hours and day byte. Bit 7 of every byte is a mask: a masked byte takes no part in the comparison. When the timekeeping chain signals a time update, both settings are compared with the current BCD time. A full match raises a sticky request flag for that alarm. The host interface, which does the register decoding, reports through a strobe whenever its address pointer lands on one of an alarm's registers. That access clears the alarm's flag.

Alarm 0 drives an active-low level interrupt. It stays asserted while the flag and the enable of alarm 0 are both set. Alarm 1 drives a one-shot active-high pulse, timed in periods of a slow timebase enable. A small state machine produces the pulse. Its states are P_IDLE (waiting), P_PULSE (output high, counting slow ticks) and P_SPENT (pulse delivered, waiting for the flag to clear). The transitions are arm (P_IDLE to P_PULSE when the flag and the enable are both set), expire (P_PULSE to P_SPENT after PULSE_TICKS slow ticks), gate-off (P_PULSE to P_SPENT when the enable drops) and rearm (P_SPENT to P_IDLE once the flag is clear).

Top module: `tod_alarm_cmp`

## Requirements
- R1: After reset, every alarm byte is 0x00 (unmasked, value zero), both flags are 0, int_lvl_n is 1 and int_pulse is 0.
- R2: A cycle with reg_wr high stores reg_wdata into the byte of alarm reg_alarm that reg_field selects: 0 is seconds, 1 is minutes, 2 is hours and 3 is day. Bit 7 is the mask and bits 6:0 hold the value. For the day byte only bits 2:0 are kept.
- R3: An alarm matches when every unmasked byte equals the current time. Seconds, minutes and hours compare all seven bits, so the hours compare includes bit 6 (12-hour mode) and bit 5 (PM, or the 20-hour digit). The day byte compares its three bits. A masked byte matches whatever its stored value.
- R4: The mask combinations give these repeat rates: all four masked (every update), only seconds compared, seconds and minutes compared, seconds to hours compared, and all four compared (weekly).
- R5: req_flag[0] (alarm 0) and req_flag[1] (alarm 1) are set at the clock edge that ends a cycle with upd_tick high and a match. A match with upd_tick low sets nothing.
- R6: touch[i], or a write to alarm i, clears req_flag[i] at the next edge. The other alarm's flag is not affected.
- R7: If a set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R8: int_lvl_n is 0 exactly while req_flag[0] and ie[0] are both 1.
- R9: After req_flag[1] and ie[1] are both 1, int_pulse rises one cycle later. It stays high until PULSE_TICKS slow_tick cycles have passed, which is 2048 cycles when slow_tick is held high.
- R10: A match that comes during the pulse does not lengthen it. After the pulse there is no new pulse until req_flag[1] has been cleared.
- R11: While ie[1] is 0, int_pulse is held at 0. Dropping ie[1] during a pulse ends the pulse at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_tick | input | 1 | One-cycle strobe marking a time update |
| slow_tick | input | 1 | Slow timebase enable that times the pulse |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours, with the 12/24 and PM bits |
| now_day | input | 3 | Current day of the week |
| reg_wr | input | 1 | Alarm byte write strobe |
| reg_alarm | input | 1 | Alarm index of the write |
| reg_field | input | 2 | Byte select of the write |
| reg_wdata | input | 8 | Write data, with bit 7 as the mask |
| touch | input | 2 | Access strobe for the registers of each alarm |
| ie | input | 2 | Interrupt enable for each alarm |
| req_flag | output | 2 | Sticky request flags |
| int_lvl_n | output | 1 | Active-low level interrupt for alarm 0 |
| int_pulse | output | 1 | Active-high one-shot pulse for alarm 1 |

## Verification
The assertions take upd_tick to be a single-cycle strobe. They take slow_tick to be the only thing that advances the pulse timer, and the time inputs to be stable around each update. They rely on a flag changing only in response to upd_tick, touch or a write. The stimulus writes every alarm byte before it presents a time. It raises upd_tick for exactly one cycle and holds slow_tick high, so the pulse length is an exact cycle count. It changes ie and touch only at falling edges, away from the edge that samples them.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

    localparam int VAL_W   = 7;
    localparam int DAY_W   = 3;
    localparam int BYTE_W  = VAL_W + 1;
    localparam int N_ALARM = 2;

    localparam logic [1:0] SEL_SEC  = 2'd0;
    localparam logic [1:0] SEL_MIN  = 2'd1;
    localparam logic [1:0] SEL_HOUR = 2'd2;
    localparam logic [1:0] SEL_DAY  = 2'd3;

    typedef enum logic [1:0] {
        P_IDLE  = 2'd0,
        P_PULSE = 2'd1,
        P_SPENT = 2'd2
    } pulse_state_t;

    // a byte passes when masked or when its value field equals the time
    function automatic logic byte_passes(input logic [BYTE_W-1:0] cfg,
                                         input logic [VAL_W-1:0]  now);
        return cfg[BYTE_W-1] | (cfg[VAL_W-1:0] == now);
    endfunction

endpackage

// File: rtl/tod_alarm_bank.sv
module tod_alarm_bank
    import tod_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] cfg_sec,
    output logic [BYTE_W-1:0] cfg_min,
    output logic [BYTE_W-1:0] cfg_hour,
    output logic [BYTE_W-1:0] cfg_day
);

    localparam int PAD_W = VAL_W - DAY_W;

    logic [BYTE_W-1:0] day_clean;

    // the unused day value bits are kept at zero
    always_comb begin
        day_clean = {wdata[BYTE_W-1], {PAD_W{1'b0}}, wdata[DAY_W-1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_sec  <= '0;
            cfg_min  <= '0;
            cfg_hour <= '0;
            cfg_day  <= '0;
        end else if (we) begin
            unique case (sel)
                SEL_SEC:  cfg_sec  <= wdata;
                SEL_MIN:  cfg_min  <= wdata;
                SEL_HOUR: cfg_hour <= wdata;
                SEL_DAY:  cfg_day  <= day_clean;
                default:  cfg_sec  <= cfg_sec;
            endcase
        end
    end

endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
    import tod_alarm_pkg::*;
(
    input  logic [BYTE_W-1:0] cfg_sec,
    input  logic [BYTE_W-1:0] cfg_min,
    input  logic [BYTE_W-1:0] cfg_hour,
    input  logic [BYTE_W-1:0] cfg_day,
    input  logic [VAL_W-1:0]  now_sec,
    input  logic [VAL_W-1:0]  now_min,
    input  logic [VAL_W-1:0]  now_hour,
    input  logic [DAY_W-1:0]  now_day,
    output logic              hit
);

    localparam int PAD_W = VAL_W - DAY_W;

    logic [3:0]       pass;
    logic [VAL_W-1:0] day_wide;

    always_comb begin
        day_wide = {{PAD_W{1'b0}}, now_day};
        pass[0]  = byte_passes(cfg_sec,  now_sec);
        pass[1]  = byte_passes(cfg_min,  now_min);
        pass[2]  = byte_passes(cfg_hour, now_hour);
        pass[3]  = byte_passes(cfg_day,  day_wide);
        hit      = &pass;
    end

endmodule

// File: rtl/tod_alarm_flag.sv
module tod_alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    // set takes priority over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/tod_alarm_pulse.sv
module tod_alarm_pulse
    import tod_alarm_pkg::*;
#(
    parameter int PULSE_TICKS = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_tick,
    input  logic flag,
    input  logic en,
    output logic pulse
);

    localparam int CNT_W = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_TICKS - 1);

    pulse_state_t     state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             expire;

    always_comb begin
        expire = slow_tick && (cnt == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= P_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            P_IDLE: begin
                if (flag && en) state_nx = P_PULSE;      // arm
            end
            P_PULSE: begin
                if (!en)        state_nx = P_SPENT;      // gate-off
                else if (expire) state_nx = P_SPENT;     // expire
            end
            P_SPENT: begin
                if (!flag)      state_nx = P_IDLE;       // rearm
            end
            default:            state_nx = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state != P_PULSE) begin
            cnt <= '0;
        end else if (slow_tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        pulse = (state == P_PULSE);
    end

endmodule

// File: rtl/tod_alarm_cmp.sv
module tod_alarm_cmp
    import tod_alarm_pkg::*;
#(
    parameter int PULSE_TICKS = 2048
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        upd_tick,
    input  logic        slow_tick,
    input  logic [6:0]  now_sec,
    input  logic [6:0]  now_min,
    input  logic [6:0]  now_hour,
    input  logic [2:0]  now_day,
    input  logic        reg_wr,
    input  logic        reg_alarm,
    input  logic [1:0]  reg_field,
    input  logic [7:0]  reg_wdata,
    input  logic [1:0]  touch,
    input  logic [1:0]  ie,
    output logic [1:0]  req_flag,
    output logic        int_lvl_n,
    output logic        int_pulse
);

    logic [N_ALARM-1:0] hit;
    logic [N_ALARM-1:0] wr_sel;
    logic [N_ALARM-1:0] clr;
    logic [N_ALARM-1:0] set;

    for (genvar i = 0; i < N_ALARM; i++) begin : g_alarm
        logic [BYTE_W-1:0] c_sec, c_min, c_hour, c_day;

        always_comb begin
            wr_sel[i] = reg_wr && (reg_alarm == 1'(i));
            clr[i]    = touch[i] || wr_sel[i];
            set[i]    = upd_tick && hit[i];
        end

        tod_alarm_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (wr_sel[i]),
            .sel      (reg_field),
            .wdata    (reg_wdata),
            .cfg_sec  (c_sec),
            .cfg_min  (c_min),
            .cfg_hour (c_hour),
            .cfg_day  (c_day)
        );

        tod_alarm_match u_match (
            .cfg_sec  (c_sec),
            .cfg_min  (c_min),
            .cfg_hour (c_hour),
            .cfg_day  (c_day),
            .now_sec  (now_sec),
            .now_min  (now_min),
            .now_hour (now_hour),
            .now_day  (now_day),
            .hit      (hit[i])
        );

        tod_alarm_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set[i]),
            .clr   (clr[i]),
            .flag  (req_flag[i])
        );
    end

    always_comb begin
        int_lvl_n = ~(req_flag[0] & ie[0]);
    end

    tod_alarm_pulse #(
        .PULSE_TICKS (PULSE_TICKS)
    ) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .flag      (req_flag[1]),
        .en        (ie[1]),
        .pulse     (int_pulse)
    );

endmodule

// File: rtl/tod_alarm_chk.sv
module tod_alarm_chk #(
    parameter int PULSE_TICKS = 2048
) (
    input logic       clk,
    input logic       rst_n,
    input logic       upd_tick,
    input logic       slow_tick,
    input logic       reg_wr,
    input logic       reg_alarm,
    input logic [1:0] touch,
    input logic [1:0] ie,
    input logic [1:0] req_flag,
    input logic       int_lvl_n,
    input logic       int_pulse
);

    localparam int LEN_W = $clog2(PULSE_TICKS + 1) + 1;

    logic [LEN_W-1:0] hi_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_ticks <= '0;
        end else if (!int_pulse) begin
            hi_ticks <= '0;
        end else if (slow_tick) begin
            hi_ticks <= hi_ticks + 1'b1;
        end
    end

    // R5
    flag0_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_flag[0]) |-> $past(upd_tick));

    // R5
    flag1_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_flag[1]) |-> $past(upd_tick));

    // R6
    flag0_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_flag[0]) |-> $past(touch[0] || (reg_wr && !reg_alarm)));

    // R6
    flag1_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_flag[1]) |-> $past(touch[1] || (reg_wr && reg_alarm)));

    // R8
    lvl_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_lvl_n |-> (req_flag[0] && ie[0]));

    // R9
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_pulse) |-> $past(req_flag[1] && ie[1]));

    // R9
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_pulse |-> (hi_ticks < LEN_W'(PULSE_TICKS)));

    // R11
    pulse_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ie[1] |=> !int_pulse);

endmodule

bind tod_alarm_cmp tod_alarm_chk #(
    .PULSE_TICKS (PULSE_TICKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_tick  (upd_tick),
    .slow_tick (slow_tick),
    .reg_wr    (reg_wr),
    .reg_alarm (reg_alarm),
    .touch     (touch),
    .ie        (ie),
    .req_flag  (req_flag),
    .int_lvl_n (int_lvl_n),
    .int_pulse (int_pulse)
);

// File: tb/tod_alarm_cmp_bench.sv
module tod_alarm_cmp_bench;

    localparam int PT = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_tick = 1'b0;
    logic       slow_tick = 1'b1;
    logic [6:0] now_sec = '0;
    logic [6:0] now_min = '0;
    logic [6:0] now_hour = '0;
    logic [2:0] now_day = '0;
    logic       reg_wr = 1'b0;
    logic       reg_alarm = 1'b0;
    logic [1:0] reg_field = '0;
    logic [7:0] reg_wdata = '0;
    logic [1:0] touch = '0;
    logic [1:0] ie = '0;
    logic [1:0] req_flag;
    logic       int_lvl_n;
    logic       int_pulse;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tod_alarm_cmp #(.PULSE_TICKS(PT)) u_tod_alarm_cmp (
        .clk(clk), .rst_n(rst_n), .upd_tick(upd_tick), .slow_tick(slow_tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_day(now_day),
        .reg_wr(reg_wr), .reg_alarm(reg_alarm), .reg_field(reg_field),
        .reg_wdata(reg_wdata), .touch(touch), .ie(ie),
        .req_flag(req_flag), .int_lvl_n(int_lvl_n), .int_pulse(int_pulse)
    );

    // {alarm sec,min,hour,day ; time sec,min,hour,day ; expected match}
    localparam logic [64:0] VEC [11] = '{
        {64'h80808080_13270503, 1'b1},  // R4 every update
        {64'h30808080_30110402, 1'b1},  // R4 seconds compared
        {64'h30808080_31110402, 1'b0},  // R3 seconds differ
        {64'h15428080_15421906, 1'b1},  // R4 seconds+minutes
        {64'h15428080_15431906, 1'b0},  // R3 minutes differ
        {64'h00302380_00302301, 1'b1},  // R4 daily, 24-hour
        {64'h00007180_00005104, 1'b0},  // R3 PM vs AM bit differs
        {64'h00007180_00007104, 1'b1},  // R3 12-hour PM equal
        {64'h59592307_59592307, 1'b1},  // R4 weekly
        {64'h59592307_59592306, 1'b0},  // R3 day differs
        {64'h05809580_05330805, 1'b1}   // R3 masked bytes ignore values
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic al, input logic [1:0] fld, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_alarm = al; reg_field = fld; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic prog(input logic al, input logic [31:0] b);
        wr(al, 2'd0, b[31:24]);
        wr(al, 2'd1, b[23:16]);
        wr(al, 2'd2, b[15:8]);
        wr(al, 2'd3, b[7:0]);
    endtask

    task automatic tick(input logic [1:0] tch);
        @(negedge clk);
        upd_tick = 1'b1; touch = tch;
        @(negedge clk);
        upd_tick = 1'b0; touch = 2'b00;
    endtask

    task automatic wait_rise(output bit seen);
        seen = 0;
        for (int k = 0; k < 6 && !seen; k++) begin
            if (int_pulse) seen = 1;
            else @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit seen;
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 flags", 32'(req_flag), 0);
        chk("R1 int_lvl_n", 32'(int_lvl_n), 1);
        chk("R1 int_pulse", 32'(int_pulse), 0);
        // R1 reset bytes are zero and unmasked: day 0 time 00:00:00 matches
        tick(2'b00);
        chk("R1 zero alarm matches zero time", 32'(req_flag[0]), 1);
        wr(1'b0, 2'd0, 8'h00);
        chk("R6 write clears flag", 32'(req_flag[0]), 0);

        // vector table, R2 R3 R4 R8
        ie = 2'b01;
        foreach (VEC[i]) begin
            prog(1'b0, VEC[i][64:33]);
            now_sec = VEC[i][31:25]; now_min = VEC[i][23:17];
            now_hour = VEC[i][15:9]; now_day = VEC[i][3:1];
            tick(2'b00);
            chk("R3/R4 flag", 32'(req_flag[0]), 32'(VEC[i][0]));
            chk("R8 level irq", 32'(int_lvl_n), 32'(!VEC[i][0]));
        end

        // R5 match without update does nothing
        prog(1'b0, 32'h80808080);
        repeat (3) @(negedge clk);
        chk("R5 no tick no set", 32'(req_flag[0]), 0);
        tick(2'b00);
        chk("R5 set on tick", 32'(req_flag[0]), 1);
        // R6 other alarm's access leaves flag 0 alone
        @(negedge clk); touch = 2'b10; @(negedge clk); touch = 2'b00;
        chk("R6 touch1 keeps flag0", 32'(req_flag[0]), 1);
        @(negedge clk); touch = 2'b01; @(negedge clk); touch = 2'b00;
        chk("R6 touch0 clears flag0", 32'(req_flag[0]), 0);
        // R7 set wins over clear
        tick(2'b01);
        chk("R7 set wins", 32'(req_flag[0]), 1);
        // R8 enable off
        ie[0] = 1'b0;
        @(negedge clk);
        chk("R8 disabled level", 32'(int_lvl_n), 1);

        // R9 R10 pulse
        ie = 2'b10;
        prog(1'b1, 32'h80808080);
        chk("R11 no pulse before flag", 32'(int_pulse), 0);
        tick(2'b00);
        chk("R5 flag1 set", 32'(req_flag[1]), 1);
        chk("R9 not yet high", 32'(int_pulse), 0);
        wait_rise(seen);
        chk("R9 pulse rises", 32'(seen), 1);
        hi = 0;
        while (int_pulse && hi < 5000) begin
            hi++;
            upd_tick = (hi == 1000);
            @(negedge clk);
        end
        upd_tick = 1'b0;
        chk("R9/R10 pulse length", 32'(hi), 32'(PT));
        repeat (50) @(negedge clk);
        chk("R10 one pulse per flag", 32'(int_pulse), 0);
        // R10 re-arm after clear
        @(negedge clk); touch = 2'b10; @(negedge clk); touch = 2'b00;
        chk("R6 touch1 clears flag1", 32'(req_flag[1]), 0);
        tick(2'b00);
        wait_rise(seen);
        chk("R10 rearmed pulse", 32'(seen), 1);
        // R11 dropping enable ends pulse
        repeat (10) @(negedge clk);
        ie[1] = 1'b0;
        @(negedge clk);
        chk("R11 gate-off", 32'(int_pulse), 0);
        ie[1] = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 no restart while flagged", 32'(int_pulse), 0);
        // R11 enable low holds output low
        ie[1] = 1'b0;
        wr(1'b1, 2'd0, 8'h80);
        tick(2'b00);
        repeat (5) @(negedge clk);
        chk("R11 flag1 set", 32'(req_flag[1]), 1);
        chk("R11 held low", 32'(int_pulse), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule